// File: doc/BRIEF.md
# Clear-on-Read Event Statistics Bank

This block counts events reported by a wireless frame engine: checksum failures, checksum-good frames, duplicates, length faults, rate faults and similar. Every event source drives a single-cycle strobe into its own byte-wide counter. Two counters are packed into each 16-bit register. Software reads a register to collect a pair of counts, and the same read sets both counts back to zero. No explicit reset of the counters is needed.

Alongside the counters the block keeps two sticky bitmasks, with one bit per counter. The first records that a counter has advanced at least once. The second records that a counter has wrapped past its maximum. Each mask has its own enable mask. A mask bit ANDed with its enable bit drives one of two interrupt request lines: one for count-up, one for overflow. Reading a mask returns its contents and clears it, which also acknowledges the matching interrupt.

Top module: `stat_bank`

## Requirements
- R1: A one-cycle strobe on `evt_i[i]` adds one to 8-bit counter i. Counter 2k sits in bits 7:0 and counter 2k+1 sits in bits 15:8 of the pair register at address k, for k = 0..7.
- R2: A read (`rd_en_i` high for one cycle) returns its data on `rdata_o` in the following cycle. A read of a pair register returns both counts and sets both counters to 0.
- R3: A counter holding 255 that receives a strobe wraps to 0 and sets bit i of the overflow mask.
- R4: Any strobe on counter i sets bit i of the count-up mask (address 8). The bit stays set until that mask is read.
- R5: A read of the count-up mask (address 8) or of the overflow mask (address 9) returns the mask and clears it.
- R6: The count-up enable (address 10) and the overflow enable (address 11) can be written and read back. Bit i of each enable belongs to counter i: bit 5 is checksum error, bit 6 is checksum good, bit 11 is duplicate frame.
- R7: `irq_cnt_o` is high whenever some count-up mask bit and its enable bit are both 1. It rises in the cycle after the strobe that sets the bit.
- R8: `irq_ovf_o` is high whenever some overflow mask bit and its enable bit are both 1.
- R9: A strobe that arrives in the same cycle as the clearing read leaves its counter at 1, and the read returns the old count. A strobe that coincides with a mask read leaves its mask bit set.
- R10: Writes to pair registers or to mask addresses have no effect on counters or masks.
- R11: After reset all counters, masks and enables are 0, both interrupts are low and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | One event strobe per counter |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after the read |
| irq_cnt_o | output | 1 | Count-up interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
The hardest cases to reach are those where a strobe lands in the exact cycle of a clearing read, for a counter or for a mask. The bench raises the strobe and the read strobe on the same falling edge, so both are sampled at one rising edge. It then reads again to confirm that exactly one event survived. Overflow needs 256 strobes on one counter. The bench checks that the overflow interrupt stays low after 255 strobes and rises only on the 256th.

// File: rtl/stat_pkg.sv
package stat_pkg;
    typedef enum logic [2:0] {
        RK_PAIR,
        RK_INC_MASK,
        RK_OVF_MASK,
        RK_INC_EN,
        RK_OVF_EN,
        RK_NONE
    } reg_kind_e;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (clr_i) begin
            st_d.count = evt_i ? CNT_W'(1) : '0;
        end else if (evt_i) begin
            st_d.count = st_q.count + CNT_W'(1);
            wrap_o     = (st_q.count == MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !clr_i && count_o != MAX) |=> count_o == $past(count_o) + CNT_W'(1)); // R1
    AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> count_o == '0); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> count_o == '0); // R3
    AST_COLLIDE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i) |=> count_o == CNT_W'(1)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !evt_i) |=> $stable(count_o)); // R10
endmodule

// File: rtl/stat_sticky.sv
module stat_sticky #(
    parameter int NUM_CNT = 16,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] set_i,
    input  logic               clr_i,
    input  logic               en_wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_CNT-1:0] mask_o,
    output logic [NUM_CNT-1:0] en_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_CNT-1:0] mask;
        logic [NUM_CNT-1:0] en;
    } sticky_st_t;

    sticky_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mask = (clr_i ? '0 : st_q.mask) | set_i;
        if (en_wr_i) st_d.en = NUM_CNT'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign en_o   = st_q.en;
    assign irq_o  = |(st_q.mask & st_q.en);

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((mask_o & $past(set_i)) == $past(set_i))); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && set_i == '0) |=> $stable(mask_o)); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> mask_o == '0); // R5
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> en_o == NUM_CNT'($past(wdata_i))); // R6
endmodule

// File: rtl/stat_regif.sv
module stat_regif
    import stat_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] count_i,
    input  logic [NUM_CNT-1:0]            inc_mask_i,
    input  logic [NUM_CNT-1:0]            ovf_mask_i,
    input  logic [NUM_CNT-1:0]            inc_en_i,
    input  logic [NUM_CNT-1:0]            ovf_en_i,
    output logic [NUM_CNT/2-1:0]          pair_clr_o,
    output logic                          inc_clr_o,
    output logic                          ovf_clr_o,
    output logic                          inc_en_wr_o,
    output logic                          ovf_en_wr_o,
    output logic [2*CNT_W-1:0]            rdata_o
);
    localparam int NPAIR  = NUM_CNT / 2;
    localparam int DATA_W = 2 * CNT_W;
    localparam int PIDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
    localparam logic [ADDR_W-1:0] A_INC_MASK = ADDR_W'(NPAIR);
    localparam logic [ADDR_W-1:0] A_OVF_MASK = ADDR_W'(NPAIR + 1);
    localparam logic [ADDR_W-1:0] A_INC_EN   = ADDR_W'(NPAIR + 2);
    localparam logic [ADDR_W-1:0] A_OVF_EN   = ADDR_W'(NPAIR + 3);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rif_st_t;

    rif_st_t     st_d, st_q;
    reg_kind_e   kind;
    logic [PIDX_W-1:0] pidx;
    logic [DATA_W-1:0] rsel;

    always_comb begin
        if (addr_i < ADDR_W'(NPAIR))  kind = RK_PAIR;
        else if (addr_i == A_INC_MASK) kind = RK_INC_MASK;
        else if (addr_i == A_OVF_MASK) kind = RK_OVF_MASK;
        else if (addr_i == A_INC_EN)   kind = RK_INC_EN;
        else if (addr_i == A_OVF_EN)   kind = RK_OVF_EN;
        else                           kind = RK_NONE;
        pidx = addr_i[PIDX_W-1:0];
    end

    always_comb begin
        pair_clr_o = '0;
        rsel       = '0;
        for (int k = 0; k < NPAIR; k++) begin
            if (kind == RK_PAIR && pidx == PIDX_W'(k)) begin
                rsel          = {count_i[2*k+1], count_i[2*k]};
                pair_clr_o[k] = rd_en_i;
            end
        end
        case (kind)
            RK_INC_MASK: rsel = DATA_W'(inc_mask_i);
            RK_OVF_MASK: rsel = DATA_W'(ovf_mask_i);
            RK_INC_EN:   rsel = DATA_W'(inc_en_i);
            RK_OVF_EN:   rsel = DATA_W'(ovf_en_i);
            default:     ;
        endcase
        inc_clr_o   = rd_en_i && kind == RK_INC_MASK;
        ovf_clr_o   = rd_en_i && kind == RK_OVF_MASK;
        inc_en_wr_o = wr_en_i && kind == RK_INC_EN;
        ovf_en_wr_o = wr_en_i && kind == RK_OVF_EN;
        st_d        = st_q;
        if (rd_en_i) st_d.rdata = rsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    AST_ONE_PAIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pair_clr_o)); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R2
    AST_WRITE_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (pair_clr_o == '0 && !inc_clr_o && !ovf_clr_o)); // R10
endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 8,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [2*CNT_W-1:0] wdata_i,
    output logic [2*CNT_W-1:0] rdata_o,
    output logic               irq_cnt_o,
    output logic               irq_ovf_o
);
    localparam int NPAIR  = NUM_CNT / 2;
    localparam int DATA_W = 2 * CNT_W;

    logic [NUM_CNT-1:0][CNT_W-1:0] count;
    logic [NUM_CNT-1:0]            wrap;
    logic [NPAIR-1:0]              pair_clr;
    logic                          inc_clr, ovf_clr, inc_en_wr, ovf_en_wr;
    logic [NUM_CNT-1:0]            inc_mask, ovf_mask, inc_en, ovf_en;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        stat_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[i]),
            .clr_i   (pair_clr[i/2]),
            .count_o (count[i]),
            .wrap_o  (wrap[i])
        );
    end

    stat_sticky #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) i_inc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_i),
        .clr_i   (inc_clr),
        .en_wr_i (inc_en_wr),
        .wdata_i (wdata_i),
        .mask_o  (inc_mask),
        .en_o    (inc_en),
        .irq_o   (irq_cnt_o)
    );

    stat_sticky #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) i_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wrap),
        .clr_i   (ovf_clr),
        .en_wr_i (ovf_en_wr),
        .wdata_i (wdata_i),
        .mask_o  (ovf_mask),
        .en_o    (ovf_en),
        .irq_o   (irq_ovf_o)
    );

    stat_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (rd_en_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .count_i     (count),
        .inc_mask_i  (inc_mask),
        .ovf_mask_i  (ovf_mask),
        .inc_en_i    (inc_en),
        .ovf_en_i    (ovf_en),
        .pair_clr_o  (pair_clr),
        .inc_clr_o   (inc_clr),
        .ovf_clr_o   (ovf_clr),
        .inc_en_wr_o (inc_en_wr),
        .ovf_en_wr_o (ovf_en_wr),
        .rdata_o     (rdata_o)
    );

    AST_IRQ_CNT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cnt_o |-> (inc_en != '0)); // R7
    AST_IRQ_OVF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf_o |-> (ovf_mask != '0)); // R8
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> (ovf_mask & $past(wrap)) == $past(wrap)); // R3
endmodule

// File: tb/test_stat_bank.sv
module test_stat_bank;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_cnt, irq_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_bank i_stat_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_cnt_o(irq_cnt), .irq_ovf_o(irq_ovf)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            evt[idx] = 1'b1;
            @(negedge clk);
            evt[idx] = 1'b0;
        end
    endtask

    task automatic clear_all();
        logic [15:0] d;
        for (int a = 0; a < 10; a++) reg_rd(4'(a), d);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R11 irq_cnt", 16'(irq_cnt), 16'h0);
        check("R11 irq_ovf", 16'(irq_ovf), 16'h0);
        check("R11 rdata", rdata, 16'h0);
        for (int a = 0; a < 12; a++) begin
            reg_rd(4'(a), d);
            check("R11 register", d, 16'h0);
        end
    endtask

    task automatic t_count();
        logic [15:0] d;
        clear_all();
        pulse(5, 3);
        pulse(6, 1);
        pulse(9, 2);
        reg_rd(4'd2, d); check("R1 pair2 high byte", d, 16'h0300);
        reg_rd(4'd3, d); check("R1 pair3 low byte", d, 16'h0001);
        reg_rd(4'd4, d); check("R1 pair4 high byte", d, 16'h0200);
        reg_rd(4'd2, d); check("R2 pair2 cleared", d, 16'h0000);
        reg_rd(4'd8, d); check("R4 count-up mask", d, 16'h0260);
        reg_rd(4'd8, d); check("R5 mask cleared by read", d, 16'h0000);
    endtask

    task automatic t_irq_cnt();
        logic [15:0] d;
        clear_all();
        reg_wr(4'd10, 16'h0800);
        reg_rd(4'd10, d); check("R6 count-up enable readback", d, 16'h0800);
        pulse(5, 1);
        check("R7 disabled bit gives no irq", 16'(irq_cnt), 16'h0);
        pulse(11, 1);
        check("R7 duplicate bit raises irq", 16'(irq_cnt), 16'h1);
        reg_rd(4'd8, d); check("R4 mask holds both", d, 16'h0820);
        check("R7 irq drops after mask read", 16'(irq_cnt), 16'h0);
        reg_wr(4'd10, 16'h0000);
    endtask

    task automatic t_overflow();
        logic [15:0] d;
        clear_all();
        reg_wr(4'd11, 16'h0001);
        reg_rd(4'd11, d); check("R6 overflow enable readback", d, 16'h0001);
        pulse(0, 255);
        check("R8 no irq at 255", 16'(irq_ovf), 16'h0);
        pulse(0, 1);
        check("R8 irq after wrap", 16'(irq_ovf), 16'h1);
        reg_rd(4'd9, d); check("R3 overflow mask bit0", d, 16'h0001);
        check("R8 irq drops after read", 16'(irq_ovf), 16'h0);
        reg_rd(4'd0, d); check("R3 counter wrapped to 0", d, 16'h0000);
        reg_wr(4'd11, 16'h0000);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        clear_all();
        pulse(2, 2);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'd1; evt[2] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; evt[2] = 1'b0;
        check("R9 read returns old count", rdata, 16'h0002);
        reg_rd(4'd1, d); check("R9 counter left at 1", d, 16'h0001);
        reg_rd(4'd8, d);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'd8; evt[3] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; evt[3] = 1'b0;
        check("R9 mask read returns old", rdata, 16'h0000);
        reg_rd(4'd8, d); check("R9 mask bit survives", d, 16'h0008);
    endtask

    task automatic t_ignored_writes();
        logic [15:0] d;
        clear_all();
        pulse(7, 1);
        reg_wr(4'd3, 16'hFFFF);
        reg_wr(4'd8, 16'h0000);
        reg_wr(4'd9, 16'hFFFF);
        reg_rd(4'd3, d); check("R10 pair write ignored", d, 16'h0100);
        reg_rd(4'd8, d); check("R10 mask write ignored", d, 16'h0080);
        reg_rd(4'd9, d); check("R10 overflow write ignored", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_irq_cnt();
        t_overflow();
        t_collide();
        t_ignored_writes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule